// File: doc/BRIEF.md
# Dual Timer Register Interface

This block is the host-facing register file for a pair of down-counting timer channels, called A (channel 0) and B (channel 1). A byte-wide bus reaches it through a 3-bit address, a chip select and separate read and write strobes. Writes load each channel's 16-bit preload value one byte at a time, or load its 8-bit control word. Reads return a channel's holding register one byte at a time, or a status byte that the two channels share. The counting engines themselves live outside the block. They supply the live count, a count-clock tick, a timeout pulse and their output level. In return they receive the preload value, the control word and a one-cycle strobe that marks each control write.

A write takes effect only after the write strobe falls, so the address and data must be valid while the strobe is high. The holding register follows the live count unless the control word asks it to freeze. A frozen channel can take one fresh snapshot on the next count tick, which lets software read both bytes of the count consistently while the counter keeps running. Each channel latches its timeout only when its interrupt-enable bit is set. The latched timeouts of both channels drive one shared active-low interrupt output. A control write clears the latched timeout of its own channel only.

Top module: `dual_timer_regs`

## Requirements
- R1: A write commits on the first clock edge after the write strobe falls, using the address and data captured while the strobe and chip select were both high. A strobe given with chip select low changes nothing.
- R2: A committed write to address 2 (A) or 3 (B) sets bits 15..8 of that channel's preload. A write to address 4 (A) or 5 (B) sets bits 7..0. Writes to addresses 0 and 1 change no register.
- R3: A committed write to address 6 (A) or 7 (B) stores the control word. In the cycle after the commit edge, that channel's control-write strobe is high for exactly one cycle and the new word is on the control output.
- R4: While chip select and read are both high, the read data depends on the address. Addresses 2/3 return bits 15..8 of the A/B holding register, and 4/5 return bits 7..0. Addresses 6 and 7 both return the status byte: bit 7 is A's latched timeout, bit 6 is B's, and bits 5..0 are zero. Addresses 0 and 1 return 00.
- R5: A timeout pulse seen while control bit 4 (interrupt enable) is 1 latches that channel's status bit and pulls the interrupt output low. With bit 4 at 0, a timeout changes neither.
- R6: A control write clears its own channel's latched timeout and leaves the other channel's latched timeout unchanged. The interrupt output goes high once neither channel has a latched timeout.
- R7: While control bit 6 is 0, the holding register loads the live count on every clock. Writing bit 6 as 1 freezes it; the next count tick after that write captures one fresh count, and it then holds until bit 6 is written again.
- R8: While reset is low, the timer outputs are low, the complement outputs are high, the interrupt output is high and the status byte reads 00.
- R9: The read data is 00 and the read-enable output is low whenever chip select and read are not both high.
- R10: Each timer output equals that channel's level input as sampled on the previous clock edge, and its complement output is the inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write strobe; the write commits after it falls |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 00 when the block is not being read |
| rdata_oe_o | output | 1 | High while the read data should be driven onto the bus |
| count_i | input | 2x16 | Live count of each channel |
| tick_i | input | 2 | Count-clock tick of each channel |
| timeout_i | input | 2 | Timeout pulse of each channel |
| level_i | input | 2 | Output level requested by each channel's engine |
| preload_o | output | 2x16 | Preload value of each channel |
| ctrl_o | output | 2x8 | Control word of each channel |
| ctrl_wr_o | output | 2 | One-cycle strobe after each control write |
| irq_no | output | 1 | Shared interrupt, active low |
| tout_o | output | 2 | Timer outputs |
| tout_no | output | 2 | Complement timer outputs |

## Verification
The assertions assume that each write strobe is a clean pulse lasting at least one clock, and that address and data stay stable while the strobe is high. They also assume that the timer engines change the count, tick and timeout inputs synchronously to the clock. The bench drives every input on the falling clock edge. It keeps the count, tick and timeout inputs quiet while a write cycle is in flight, so each commit edge has one well-defined cause. The random operations are a mix of writes to all eight addresses (including the unused ones), count steps with random ticks, timeout pulses on either or both channels, and changes of output level.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int NCH    = 2;
  localparam int DW     = 8;
  localparam int CW     = 2 * DW;
  localparam int AW     = 3;
  localparam int IEN_B  = 4;
  localparam int FRZ_B  = 6;

  // address class from addr[2:1]; channel from addr[0]
  typedef enum logic [1:0] {
    K_NONE = 2'b00,
    K_MSB  = 2'b01,
    K_LSB  = 2'b10,
    K_CTL  = 2'b11
  } acls_e;
endpackage

// File: rtl/dtr_bus_port.sv
module dtr_bus_port
  import dtr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          commit_o,
  output logic [AW-1:0] cmt_addr_o,
  output logic [DW-1:0] cmt_data_o
);
  logic wr_act, wr_q;
  assign wr_act = wr_i & cs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= 1'b0;
      cmt_addr_o <= '0;
      cmt_data_o <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        cmt_addr_o <= addr_i;
        cmt_data_o <= wdata_i;
      end
    end
  end

  // trailing edge of a selected strobe
  assign commit_o = wr_q & ~wr_act;

  p_commit_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/dtr_chan.sv
module dtr_chan
  import dtr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_msb_i,
  input  logic          we_lsb_i,
  input  logic          we_ctl_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] count_i,
  input  logic          tick_i,
  input  logic          timeout_i,
  input  logic          level_i,
  output logic [CW-1:0] preload_o,
  output logic [DW-1:0] ctrl_o,
  output logic          ctrl_wr_o,
  output logic [CW-1:0] hold_o,
  output logic          flag_o,
  output logic          tout_o,
  output logic          tout_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preload_o <= '0;
      ctrl_o    <= '0;
      ctrl_wr_o <= 1'b0;
      hold_o    <= '0;
      pend_q    <= 1'b0;
      flag_o    <= 1'b0;
      tout_o    <= 1'b0;
    end else begin
      if (we_msb_i) preload_o[CW-1:DW] <= wdata_i;
      if (we_lsb_i) preload_o[DW-1:0]  <= wdata_i;
      if (we_ctl_i) ctrl_o <= wdata_i;
      ctrl_wr_o <= we_ctl_i;

      if (we_ctl_i && wdata_i[FRZ_B]) pend_q <= 1'b1;
      else if (tick_i)                pend_q <= 1'b0;

      if (!ctrl_o[FRZ_B])         hold_o <= count_i;
      else if (pend_q && tick_i)  hold_o <= count_i;

      if (we_ctl_i)                          flag_o <= 1'b0;
      else if (timeout_i && ctrl_o[IEN_B])   flag_o <= 1'b1;

      tout_o <= level_i;
    end
  end

  assign tout_no = ~tout_o;

  p_ctl_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ctl_i |=> ctrl_wr_o && (ctrl_o == $past(wdata_i)));
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i && ctrl_o[IEN_B] && !we_ctl_i |=> flag_o);
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ctl_i |=> !flag_o);
  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[FRZ_B] && !pend_q && !we_ctl_i |=> $stable(hold_o));
  p_tout_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_o) |-> $past(level_i));
endmodule

// File: rtl/dtr_rd_mux.sv
module dtr_rd_mux
  import dtr_pkg::*;
(
  input  logic                     cs_i,
  input  logic                     rd_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [NCH-1:0][CW-1:0]   hold_i,
  input  logic [DW-1:0]            status_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     rdata_oe_o
);
  acls_e cls;
  assign cls        = acls_e'(addr_i[2:1]);
  assign rdata_oe_o = cs_i & rd_i;

  always_comb begin
    rdata_o = '0;
    if (rdata_oe_o) begin
      unique case (cls)
        K_MSB:   rdata_o = hold_i[addr_i[0]][CW-1:DW];
        K_LSB:   rdata_o = hold_i[addr_i[0]][DW-1:0];
        K_CTL:   rdata_o = status_i;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
  import dtr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   rdata_oe_o,
  input  logic [NCH-1:0][CW-1:0] count_i,
  input  logic [NCH-1:0]         tick_i,
  input  logic [NCH-1:0]         timeout_i,
  input  logic [NCH-1:0]         level_i,
  output logic [NCH-1:0][CW-1:0] preload_o,
  output logic [NCH-1:0][DW-1:0] ctrl_o,
  output logic [NCH-1:0]         ctrl_wr_o,
  output logic                   irq_no,
  output logic [NCH-1:0]         tout_o,
  output logic [NCH-1:0]         tout_no
);
  logic                   commit;
  logic [AW-1:0]          c_addr;
  logic [DW-1:0]          c_data;
  logic [NCH-1:0][CW-1:0] hold;
  logic [NCH-1:0]         flag;
  logic [DW-1:0]          status;

  dtr_bus_port u_port (
    .clk_i, .rst_ni, .cs_i, .wr_i, .addr_i, .wdata_i,
    .commit_o(commit), .cmt_addr_o(c_addr), .cmt_data_o(c_data)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = commit && (c_addr[0] == ch[0]);

    dtr_chan u_chan (
      .clk_i, .rst_ni,
      .we_msb_i (hit && c_addr[2:1] == K_MSB),
      .we_lsb_i (hit && c_addr[2:1] == K_LSB),
      .we_ctl_i (hit && c_addr[2:1] == K_CTL),
      .wdata_i  (c_data),
      .count_i  (count_i[ch]),
      .tick_i   (tick_i[ch]),
      .timeout_i(timeout_i[ch]),
      .level_i  (level_i[ch]),
      .preload_o(preload_o[ch]),
      .ctrl_o   (ctrl_o[ch]),
      .ctrl_wr_o(ctrl_wr_o[ch]),
      .hold_o   (hold[ch]),
      .flag_o   (flag[ch]),
      .tout_o   (tout_o[ch]),
      .tout_no  (tout_no[ch])
    );
    assign status[DW-1-ch] = flag[ch];
  end
  assign status[DW-1-NCH:0] = '0;
  assign irq_no = ~|flag;

  dtr_rd_mux u_mux (
    .cs_i, .rd_i, .addr_i, .hold_i(hold), .status_i(status),
    .rdata_o, .rdata_oe_o
  );

  p_status_pad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o && addr_i[2:1] == 2'b11 |-> rdata_o[DW-1-NCH:0] == '0);
endmodule

// File: tb/tb_dual_timer_regs.sv
module tb_dual_timer_regs;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs = 0, wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic oe, irq_n;
  logic [1:0][15:0] count = '0, preload;
  logic [1:0][7:0] ctrl;
  logic [1:0] tick = 0, tmo = 0, lvl = 0, ctrl_wr, tout, tout_n;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [15:0] m_pre [2] = '{default: '0};
  logic [7:0]  m_ctl [2] = '{default: '0};
  logic [15:0] m_hold[2] = '{default: '0};
  logic        m_pend[2] = '{default: 1'b0};
  logic        m_flag[2] = '{default: 1'b0};

  always #10 clk_i = ~clk_i;

  dual_timer_regs dut (
    .clk_i, .rst_ni, .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe),
    .count_i(count), .tick_i(tick), .timeout_i(tmo), .level_i(lvl),
    .preload_o(preload), .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr),
    .irq_no(irq_n), .tout_o(tout), .tout_no(tout_n)
  );

  // reference model of holding registers and timeout flags
  always @(posedge clk_i) if (rst_ni) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (!m_ctl[ch][6]) m_hold[ch] = count[ch];
      else if (m_pend[ch] && tick[ch]) m_hold[ch] = count[ch];
      if (tick[ch]) m_pend[ch] = 1'b0;
      if (tmo[ch] && m_ctl[ch][4]) m_flag[ch] = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    case (a)
      2, 3:    return m_hold[a-2][15:8];
      4, 5:    return m_hold[a-4][7:0];
      6, 7:    return {m_flag[0], m_flag[1], 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk_i); cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk_i); cs = 0; wr = 0;
    @(negedge clk_i);
    if (sel) begin
      case (a)
        3'd2, 3'd3: m_pre[a-2][15:8] = d;
        3'd4, 3'd5: m_pre[a-4][7:0] = d;
        3'd6, 3'd7: begin
          m_ctl[a-6] = d; m_flag[a-6] = 1'b0;
          if (d[6]) m_pend[a-6] = 1'b1;
          chk("R3 ctrl_wr strobe", 16'(ctrl_wr[a-6]), 16'd1);
        end
        default: ;
      endcase
    end
    if (a >= 6 && sel) begin
      @(negedge clk_i);
      chk("R3 strobe one cycle", 16'(ctrl_wr), 16'd0);
    end
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i); cs = 1; rd = 1; addr = a; #1;
    v = rdata;
    chk("R9 oe during read", 16'(oe), 16'd1);
    cs = 0; rd = 0; #1;
    chk("R9 idle bus", {7'd0, oe, rdata}, 16'd0);
  endtask

  task automatic state_chk();
    for (int ch = 0; ch < 2; ch++) begin
      chk("R2 preload", preload[ch], m_pre[ch]);
      chk("R3 ctrl", 16'(ctrl[ch]), 16'(m_ctl[ch]));
    end
    chk("R5/R6 irq", 16'(irq_n), 16'(!(m_flag[0] | m_flag[1])));
  endtask

  task automatic read_all();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd_byte(3'(a), v);
      chk(a >= 6 ? "R4 status" : (a < 2 ? "R4 unused" : "R4/R7 hold"), 16'(v), 16'(exp_rd(a)));
    end
  endtask

  task automatic step_cnt(input logic [15:0] ca, input logic [15:0] cb, input logic [1:0] tk);
    @(negedge clk_i); count[0] = ca; count[1] = cb; tick = tk;
    @(negedge clk_i); tick = 0;
  endtask

  task automatic pulse_tmo(input logic [1:0] t);
    @(negedge clk_i); tmo = t;
    @(negedge clk_i); tmo = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    lvl = 2'b11; count[0] = 16'hBEEF;
    repeat (3) @(negedge clk_i);
    chk("R8 tout low", 16'(tout), 16'd0);
    chk("R8 tout_n high", 16'(tout_n), 16'd3);
    chk("R8 irq high", 16'(irq_n), 16'd1);
    cs = 1; rd = 1; addr = 6; #1;
    chk("R8 status clear", 16'(rdata), 16'd0);
    cs = 0; rd = 0;
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    chk("R10 tout follows", 16'(tout), 16'd3);
    chk("R10 tout_n", 16'(tout_n), 16'd0);

    // R1/R2 preload bytes, select gating
    wr_reg(3'd2, 8'hA5); wr_reg(3'd4, 8'h3C);
    chk("R2 A preload", preload[0], 16'hA53C);
    wr_reg(3'd5, 8'h77, 0);
    chk("R1 cs low ignored", preload[1], 16'h0000);
    wr_reg(3'd0, 8'hFF); wr_reg(3'd1, 8'hFF);
    state_chk();
    read_all();

    // R5 timeouts
    wr_reg(3'd6, 8'h10);
    pulse_tmo(2'b01);
    chk("R5 irq low on A", 16'(irq_n), 16'd0);
    pulse_tmo(2'b10);
    rd_byte(3'd7, v);
    chk("R5 status A only", 16'(v), 16'h80);
    wr_reg(3'd7, 8'h10);
    pulse_tmo(2'b10);
    rd_byte(3'd6, v);
    chk("R5 status both", 16'(v), 16'hC0);
    // R6 clear only own channel
    wr_reg(3'd6, 8'h00);
    rd_byte(3'd6, v);
    chk("R6 A cleared B kept", 16'(v), 16'h40);
    chk("R6 irq still low", 16'(irq_n), 16'd0);
    wr_reg(3'd7, 8'h00);
    chk("R6 irq released", 16'(irq_n), 16'd1);

    // R7 freeze and snapshot
    step_cnt(16'h1234, 16'h0, 2'b00);
    rd_byte(3'd2, v); chk("R7 tracking", 16'(v), 16'h12);
    wr_reg(3'd6, 8'h40);
    step_cnt(16'h5678, 16'h0, 2'b00);
    rd_byte(3'd2, v); chk("R7 frozen before tick", 16'(v), 16'h12);
    step_cnt(16'h9ABC, 16'h0, 2'b01);
    rd_byte(3'd2, v); chk("R7 snapshot msb", 16'(v), 16'h9A);
    rd_byte(3'd4, v); chk("R7 snapshot lsb", 16'(v), 16'hBC);
    step_cnt(16'h1111, 16'h0, 2'b01);
    rd_byte(3'd2, v); chk("R7 held after snapshot", 16'(v), 16'h9A);
    wr_reg(3'd6, 8'h00);
    rd_byte(3'd4, v); chk("R7 tracking resumed", 16'(v), 16'h11);

    // R10 level follow
    @(negedge clk_i); lvl = 2'b10;
    @(negedge clk_i);
    chk("R10 tout", 16'(tout), 16'd2);
    chk("R10 tout_n", 16'(tout_n), 16'd1);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: wr_reg(3'($urandom % 8), 8'($urandom), ($urandom % 8) != 0);
        1: step_cnt(16'($urandom), 16'($urandom), 2'($urandom));
        2: pulse_tmo(2'($urandom));
        default: begin
          @(negedge clk_i); lvl = 2'($urandom);
          @(negedge clk_i);
          chk("R10 tout random", {tout, tout_n}, {12'd0, lvl, ~lvl});
        end
      endcase
      state_chk();
      if (i % 4 == 0) read_all();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule